// File: doc/BRIEF.md
# Streaming ROM Checksum Checker

This block watches a ROM image as it streams past, one byte per accepted beat, and decides whether the image satisfies the 8-bit additive checksum rule. All image bytes are added together with wraparound at the data width, and a good image adds up to zero. The load address of the image comes with the first beat. Together with a two-byte signature at the head of the image, it decides whether the rule is applied at all.

A load address whose low 20 bits equal E0000h marks a slot where an image is optional. There the checksum is only enforced when the image opens with the bytes 55h then AAh. Without that signature the result is reported as skipped. At every other load address the checksum is always enforced. One cycle after the last byte is accepted, the block pulses `done` and presents a held status code and a signature flag. Both stay put until the next image starts.

Top module: `rom_sum_check`

## Requirements
- R1: When the checksum is enforced and the sum of all accepted image bytes modulo 256 is zero, the status is pass (code 01).
- R2: When the checksum is enforced and that sum is nonzero, the status is fail (code 10).
- R3: `sig_seen` is 1 exactly when the first accepted byte of the image is 55h and the second is AAh. The order matters: AAh then 55h is not a signature.
- R4: When the low 20 bits of the load address equal E0000h, the checksum is enforced only with a signature present. Without one the status is skipped (code 11). Address bits above bit 19 play no part in this match.
- R5: At any other load address the checksum is enforced whether or not a signature is present.
- R6: `done` is high for exactly the one cycle after the beat carrying `in_last` is accepted. In that cycle `status` already carries the result, which is never 00.
- R7: An image of a single byte (start and last on the same beat) has no signature.
- R8: `status` and `sig_seen` hold their values until the next accepted start beat. A start beat that is not also last returns them to 00 and 0 in the following cycle.
- R9: After reset `done` is 0, `status` is 00 (none) and `sig_seen` is 0.
- R10: Beats with `in_valid` low are ignored: their data does not enter the sum or the signature check, and their markers have no effect.
- R11: The load address is sampled only on the start beat. Changes to `in_addr` later in the image have no effect.
- R12: A beat marked last that arrives while no image is open (no start since the previous last) produces no `done` and leaves the status unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A byte is offered on this beat |
| in_start | input | 1 | This beat holds the first image byte |
| in_last | input | 1 | This beat holds the final image byte |
| in_data | input | DATA_W (8) | Image byte |
| in_addr | input | ADDR_W (32) | Load address, sampled on the start beat |
| done | output | 1 | One-cycle result strobe |
| status | output | 2 | 00 none, 01 pass, 10 fail, 11 skipped |
| sig_seen | output | 1 | Image began with 55h, AAh |

## Verification
On every cycle, the assertions check the following. `done` only follows an accepted last beat and never carries status 00. A skipped result always has no signature and always comes from an image in the optional-image slot. An image outside that slot is never skipped. The status and signature flag only move on start or last beats, and a lone start beat clears both. Only the bench's scenarios can show that the sum itself is right under several byte patterns. The same goes for ignoring bytes on invalid beats, sampling the address only at start, telling 55h AAh apart from the reversed pair, and treating a one-byte image and stray last markers correctly.

// File: rtl/rsc_pkg.sv
package rsc_pkg;

  typedef enum logic [1:0] {
    RSC_NONE = 2'b00,
    RSC_PASS = 2'b01,
    RSC_FAIL = 2'b10,
    RSC_SKIP = 2'b11
  } rsc_status_e;

  // Decide the result from the window hit, signature and zero-sum flags.
  function automatic rsc_status_e rsc_decide(input logic in_window,
                                             input logic has_sig,
                                             input logic sum_zero);
    if (in_window && !has_sig) return RSC_SKIP;
    if (sum_zero)              return RSC_PASS;
    return RSC_FAIL;
  endfunction

  // Next index of the byte counter, saturating at its top value.
  function automatic logic [1:0] rsc_idx_step(input logic [1:0] idx);
    return (idx == 2'd3) ? idx : idx + 2'd1;
  endfunction

endpackage

// File: rtl/rsc_accum.sv
module rsc_accum #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat,
  input  logic              first,
  input  logic [DATA_W-1:0] data,
  output logic [DATA_W-1:0] sum_next,
  output logic              sum_zero
);
  logic [DATA_W-1:0] sum_q;

  // Sum including the byte of the current beat; a start byte restarts it.
  always_comb begin
    sum_next = first ? data : sum_q + data;
    sum_zero = (sum_next == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sum_q <= '0;
    else if (beat) sum_q <= sum_next;
  end
endmodule

// File: rtl/rsc_sig_detect.sv
module rsc_sig_detect #(
  parameter int                DATA_W = 8,
  parameter logic [DATA_W-1:0] SIG_LO = 8'h55,
  parameter logic [DATA_W-1:0] SIG_HI = 8'hAA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat,
  input  logic              first,
  input  logic [DATA_W-1:0] data,
  output logic              sig_next
);
  import rsc_pkg::*;

  logic [1:0] idx_q;      // bytes accepted since start, saturating
  logic       head_ok_q;  // first byte matched SIG_LO
  logic       sig_q;
  logic       second_byte;

  assign second_byte = !first && (idx_q == 2'd1);

  // Signature state after this beat; a start beat alone never has one.
  always_comb begin
    if (first)            sig_next = 1'b0;
    else if (second_byte) sig_next = head_ok_q && (data == SIG_HI);
    else                  sig_next = sig_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q     <= 2'd0;
      head_ok_q <= 1'b0;
      sig_q     <= 1'b0;
    end else if (beat) begin
      sig_q <= sig_next;
      if (first) begin
        idx_q     <= 2'd1;
        head_ok_q <= (data == SIG_LO);
      end else begin
        idx_q <= rsc_idx_step(idx_q);
      end
    end
  end
endmodule

// File: rtl/rsc_addr_match.sv
module rsc_addr_match #(
  parameter int                    ADDR_W     = 32,
  parameter int                    MATCH_BITS = 20,
  parameter logic [MATCH_BITS-1:0] MATCH_VAL  = 20'hE0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat,
  input  logic              first,
  input  logic [ADDR_W-1:0] addr,
  output logic              win_next,
  output logic              win_q
);
  logic addr_hit;

  generate
    if (MATCH_BITS >= ADDR_W) begin : g_full
      assign addr_hit = (MATCH_BITS'(addr) == MATCH_VAL);
    end else begin : g_low
      assign addr_hit = (addr[MATCH_BITS-1:0] == MATCH_VAL);
    end
  endgenerate

  // Address only counts on the start beat; later beats reuse the capture.
  assign win_next = first ? addr_hit : win_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             win_q <= 1'b0;
    else if (beat && first) win_q <= addr_hit;
  end
endmodule

// File: rtl/rsc_verdict.sv
module rsc_verdict (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       finish,
  input  logic       clear,
  input  logic       in_window,
  input  logic       has_sig,
  input  logic       sum_zero,
  output logic       done,
  output logic [1:0] status,
  output logic       sig_seen
);
  import rsc_pkg::*;

  rsc_status_e status_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done     <= 1'b0;
      status_q <= RSC_NONE;
      sig_seen <= 1'b0;
    end else begin
      done <= finish;
      if (finish) begin
        status_q <= rsc_decide(in_window, has_sig, sum_zero);
        sig_seen <= has_sig;
      end else if (clear) begin
        status_q <= RSC_NONE;
        sig_seen <= 1'b0;
      end
    end
  end

  assign status = status_q;
endmodule

// File: rtl/rom_sum_check.sv
module rom_sum_check #(
  parameter int                    DATA_W     = 8,
  parameter int                    ADDR_W     = 32,
  parameter int                    MATCH_BITS = 20,
  parameter logic [MATCH_BITS-1:0] MATCH_VAL  = 20'hE0000,
  parameter logic [DATA_W-1:0]     SIG_LO     = 8'h55,
  parameter logic [DATA_W-1:0]     SIG_HI     = 8'hAA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_start,
  input  logic              in_last,
  input  logic [DATA_W-1:0] in_data,
  input  logic [ADDR_W-1:0] in_addr,
  output logic              done,
  output logic [1:0]        status,
  output logic              sig_seen
);
  // Named internal events, also observed by the bound checker.
  logic              beat_ok;
  logic              first_beat;
  logic              frame_open_q;
  logic              finish_beat;
  logic              clear_beat;
  logic [DATA_W-1:0] sum_next;
  logic              sum_zero;
  logic              sig_next;
  logic              win_next;
  logic              frame_in_window;

  assign beat_ok     = in_valid;
  assign first_beat  = beat_ok && in_start;
  assign finish_beat = beat_ok && in_last && (in_start || frame_open_q);
  assign clear_beat  = first_beat && !in_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           frame_open_q <= 1'b0;
    else if (finish_beat) frame_open_q <= 1'b0;
    else if (first_beat)  frame_open_q <= 1'b1;
  end

  rsc_accum #(.DATA_W(DATA_W)) u_accum (
    .clk      (clk),
    .rst_n    (rst_n),
    .beat     (beat_ok),
    .first    (in_start),
    .data     (in_data),
    .sum_next (sum_next),
    .sum_zero (sum_zero)
  );

  rsc_sig_detect #(.DATA_W(DATA_W), .SIG_LO(SIG_LO), .SIG_HI(SIG_HI)) u_sig (
    .clk      (clk),
    .rst_n    (rst_n),
    .beat     (beat_ok),
    .first    (in_start),
    .data     (in_data),
    .sig_next (sig_next)
  );

  rsc_addr_match #(.ADDR_W(ADDR_W), .MATCH_BITS(MATCH_BITS), .MATCH_VAL(MATCH_VAL)) u_win (
    .clk      (clk),
    .rst_n    (rst_n),
    .beat     (beat_ok),
    .first    (in_start),
    .addr     (in_addr),
    .win_next (win_next),
    .win_q    (frame_in_window)
  );

  rsc_verdict u_verdict (
    .clk       (clk),
    .rst_n     (rst_n),
    .finish    (finish_beat),
    .clear     (clear_beat),
    .in_window (win_next),
    .has_sig   (sig_next),
    .sum_zero  (sum_zero),
    .done      (done),
    .status    (status),
    .sig_seen  (sig_seen)
  );
endmodule

// File: rtl/rom_sum_check_props.sv
module rom_sum_check_props (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_start,
  input logic       in_last,
  input logic       done,
  input logic [1:0] status,
  input logic       sig_seen,
  input logic       frame_in_window
);
  assert_done_after_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(in_valid && in_last));

  assert_done_has_status_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (status != 2'b00));

  assert_skip_no_sig_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 2'b11) |-> !sig_seen);

  assert_skip_in_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status == 2'b11) |-> frame_in_window);

  assert_enforced_outside_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !frame_in_window) |-> (status == 2'b01 || status == 2'b10));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && (in_start || in_last)) |=> ($stable(status) && $stable(sig_seen)));

  assert_start_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_start && !in_last) |=> (status == 2'b00 && !sig_seen));
endmodule

bind rom_sum_check rom_sum_check_props u_props (
  .clk             (clk),
  .rst_n           (rst_n),
  .in_valid        (in_valid),
  .in_start        (in_start),
  .in_last         (in_last),
  .done            (done),
  .status          (status),
  .sig_seen        (sig_seen),
  .frame_in_window (frame_in_window)
);

// File: tb/rom_sum_check_test.sv
module rom_sum_check_test;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [31:0] addr;
    logic [7:0]  n;
    logic [7:0]  b0;
    logic [7:0]  b1;
    logic [7:0]  fill;
    logic        fix;
    logic        gaps;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{32'h000C0000, 8'd8, 8'h55, 8'hAA, 8'h10, 1'b1, 1'b0},  // R1 pass, sig
    '{32'h000C0000, 8'd8, 8'h55, 8'hAA, 8'h10, 1'b0, 1'b1},  // R2 fail, gaps R10
    '{32'h000E0000, 8'd6, 8'h55, 8'hAA, 8'h03, 1'b1, 1'b0},  // R4 window, sig, pass
    '{32'h000E0000, 8'd6, 8'h55, 8'hAA, 8'h03, 1'b0, 1'b1},  // R4 window, sig, fail
    '{32'h000E0000, 8'd6, 8'h12, 8'h34, 8'h03, 1'b0, 1'b0},  // R4 skip
    '{32'h000F0000, 8'd5, 8'h12, 8'h34, 8'h07, 1'b1, 1'b1},  // R5 pass, no sig
    '{32'h000D0000, 8'd5, 8'h12, 8'h34, 8'h07, 1'b0, 1'b0},  // R5 fail, no sig
    '{32'hFFFE0000, 8'd4, 8'h55, 8'h00, 8'h21, 1'b1, 1'b0},  // R4 upper bits, skip
    '{32'h000E0000, 8'd2, 8'h55, 8'hAA, 8'h00, 1'b0, 1'b0},  // R3 two-byte sig, fail
    '{32'h000E0000, 8'd2, 8'hAA, 8'h55, 8'h00, 1'b0, 1'b0}   // R3 reversed -> skip
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_start = 1'b0;
  logic        in_last = 1'b0;
  logic [7:0]  in_data = 8'h00;
  logic [31:0] in_addr = 32'h0;
  logic        done;
  logic [1:0]  status;
  logic        sig_seen;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rom_sum_check uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_start(in_start),
    .in_last(in_last), .in_data(in_data), .in_addr(in_addr),
    .done(done), .status(status), .sig_seen(sig_seen)
  );

  task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Independent model of the result.
  function automatic logic [1:0] model_status(input logic [31:0] addr, input logic sig, input logic [7:0] sum);
    if (addr[19:0] == 20'hE0000 && !sig) return 2'b11;
    return (sum == 8'h00) ? 2'b01 : 2'b10;
  endfunction

  task automatic beat(input logic st, input logic la, input logic [7:0] d, input logic [31:0] a);
    @(negedge clk);
    in_valid = 1'b1; in_start = st; in_last = la; in_data = d; in_addr = a;
  endtask

  task automatic idle_beat(input logic [7:0] junk);
    @(negedge clk);
    in_valid = 1'b0; in_start = 1'b1; in_last = 1'b1; in_data = junk; in_addr = 32'h000E0000;
  endtask

  task automatic run_vec(input vec_t v);
    logic [7:0] sum = 8'h00;
    logic [7:0] b;
    logic       sig;
    logic [1:0] exp_st;
    for (int i = 0; i < int'(v.n); i++) begin
      if (i == 0) b = v.b0;
      else if (i == 1) b = v.b1;
      else if (v.fix && i == int'(v.n) - 1) b = 8'h00 - sum;
      else b = v.fill + 8'(i);
      sum += b;
      // R11: address changes after the start beat must not matter
      beat(i == 0, i == int'(v.n) - 1, b, (i == 0) ? v.addr : ~v.addr);
      if (v.gaps && i != int'(v.n) - 1) idle_beat(8'h5A + 8'(i));
    end
    sig = (v.n >= 2) && (v.b0 == 8'h55) && (v.b1 == 8'hAA);
    exp_st = model_status(v.addr, sig, sum);
    @(negedge clk);
    in_valid = 1'b0; in_start = 1'b0; in_last = 1'b0;
    check("R6", "done after last", {7'd0, done}, 8'd1);
    check((exp_st == 2'b11) ? "R4" : (exp_st == 2'b01 ? "R1" : "R2"), "status", {6'd0, status}, {6'd0, exp_st});
    check("R3", "sig_seen", {7'd0, sig_seen}, {7'd0, sig});
    @(negedge clk);
    check("R6", "done one cycle", {7'd0, done}, 8'd0);
    check("R8", "status held", {6'd0, status}, {6'd0, exp_st});
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9", "reset done", {7'd0, done}, 8'd0);
    check("R9", "reset status", {6'd0, status}, 8'd0);
    check("R9", "reset sig", {7'd0, sig_seen}, 8'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9", "idle status", {6'd0, status}, 8'd0);

    // R12: a last beat with no open image
    beat(1'b0, 1'b1, 8'h11, 32'h0);
    @(negedge clk); in_valid = 1'b0;
    check("R12", "stray last no done", {7'd0, done}, 8'd0);
    check("R12", "stray last status", {6'd0, status}, 8'd0);

    for (int k = 0; k < NV; k++) run_vec(VECS[k]);

    // R8: a start beat that is not last clears the held result
    beat(1'b1, 1'b0, 8'h55, 32'h000C0000);
    @(negedge clk); in_valid = 1'b0;
    check("R8", "start clears status", {6'd0, status}, 8'd0);
    check("R8", "start clears sig", {7'd0, sig_seen}, 8'd0);
    beat(1'b0, 1'b1, 8'hAB, 32'h0);  // sum 55+AB = 00 -> pass, no sig
    @(negedge clk); in_valid = 1'b0;
    check("R1", "two-byte pass", {6'd0, status}, 8'd1);
    check("R3", "55 AB no sig", {7'd0, sig_seen}, 8'd0);

    // R7: one-byte image in the window is skipped, outside it is enforced
    beat(1'b1, 1'b1, 8'h55, 32'h000E0000);
    @(negedge clk); in_valid = 1'b0;
    check("R7", "one byte window skip", {6'd0, status}, 8'd3);
    check("R7", "one byte no sig", {7'd0, sig_seen}, 8'd0);
    beat(1'b1, 1'b1, 8'h00, 32'h000C0000);
    @(negedge clk); in_valid = 1'b0;
    check("R7", "one byte zero pass", {6'd0, status}, 8'd1);
    check("R6", "one byte done", {7'd0, done}, 8'd1);

    // R12: stray last after a completed image leaves status alone
    beat(1'b0, 1'b1, 8'h77, 32'h0);
    @(negedge clk); in_valid = 1'b0;
    check("R12", "stray last after image", {7'd0, done}, 8'd0);
    check("R12", "status kept", {6'd0, status}, 8'd1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule